// File: doc/BRIEF.md
# Vector Load/Store Effective Width Decoder

This block holds the vector type state that a configuration instruction writes: the element width (SEW), the register grouping (LMUL) and a width-table mode. When a vector load or store issues, the block turns the instruction's two-bit width field into an effective element width and an effective register grouping. The effective grouping keeps the ratio of element width to grouping fixed. The effective width sets both the memory element size and the register element size, so no element is widened or extended. The result applies to that one instruction only and never changes the stored type state.

Indexed accesses take their data width and grouping straight from the stored type. For them the width field describes the index elements and always selects from 8, 16, 32 and 64 bits. When the relative mode is set, non-indexed accesses read the width field as a step relative to the current SEW, using one of four tables. Any result that does not fit a legal grouping or width raises an illegal-instruction flag in place of the effective settings.

All widths use log2 encoding: 3, 4, 5 and 6 stand for 8, 16, 32 and 64 bits. Groupings are signed log2 values from -3 (1/8) to +3 (8).

Top module: `vls_eew_decode`

## Requirements
- R1: After reset, every output is zero and the stored type is SEW=8 (log2 3), LMUL=1 (log2 0) with the fixed table. A non-indexed issue with code 3 then gives an effective width of log2 3 and a grouping of log2 0.
- R2: With the fixed table and a non-indexed access, width codes 0, 1 and 2 give widths 8, 16 and 32 (log2 3, 4, 5), and code 3 gives the current SEW.
- R3: The effective grouping (log2) equals the LMUL log2 plus the effective width log2 minus the SEW log2.
- R4: If a computed grouping lies outside -3..+3, the result has out_illegal=1 and all four width and grouping outputs are zero.
- R5: For an indexed access, the data width and grouping outputs equal the stored SEW and LMUL. The index width is 8, 16, 32 or 64 for codes 0 to 3 in either table mode, and the index grouping follows the rule in R3. For a non-indexed access, both index outputs are zero.
- R6: With the relative mode set and table t (0..3), the non-indexed width log2 is the SEW log2 plus code minus 3 plus t. Table 0 is {SEW/8..SEW} and table 3 is {SEW..8·SEW}.
- R7: In relative mode, a width below 8 or above 64 bits is illegal, with the same zeroed outputs as R4.
- R8: Outputs are registered one cycle after iss_valid, and out_valid is high in that cycle. In a cycle after which no issue was sampled, out_valid and all other outputs are zero.
- R9: A type write in the same cycle as an issue leaves that issue decoded with the old type. The new type applies from the next issue on.
- R10: An issue never changes the stored SEW, LMUL or table mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write the vector type state |
| cfg_sew_lg | input | 3 | New SEW, log2 of bits (3..6) |
| cfg_lmul_lg | input | 3 | New LMUL, signed log2 (-3..+3) |
| cfg_rel_mode | input | 1 | 1 selects relative width tables for non-indexed accesses |
| cfg_rel_tbl | input | 2 | Relative table number |
| iss_valid | input | 1 | A vector load/store issues this cycle |
| iss_indexed | input | 1 | 1 for an indexed access |
| iss_width | input | 2 | Width field of the instruction |
| out_valid | output | 1 | Decoded result present |
| out_illegal | output | 1 | Illegal width or grouping |
| out_data_eew_lg | output | 3 | Effective data width, log2 bits |
| out_data_emul_lg | output | 3 | Effective data grouping, signed log2 |
| out_idx_eew_lg | output | 3 | Index width, log2 bits |
| out_idx_emul_lg | output | 3 | Index grouping, signed log2 |

## Verification
The bench covers groupings at both edges of the legal range (1/8 and 8) and results just outside them. A design with an off-by-one range check would flag these wrongly or let them through. Indexed issues with code 3 must give 64-bit indices even when SEW is 8; a decoder that reused the SEW substitution here would return 8. Relative tables are driven to widths below 8 and above 64 bits, where a missing check gives a wrapped width. A type write in the same cycle as an issue, and repeated issues between writes, catch a design that forwards the new type early or lets a per-instruction width leak into the stored state.

// File: rtl/eew_pkg.sv
// Shared sizes and types for the effective width decoder.
// Widths are log2 of bits; groupings are signed log2 values.
package eew_pkg;
    localparam int LG_W        = 3;   // bits in a log2 width or grouping
    localparam int ARITH_W     = 5;   // headroom for sums of log2 values
    localparam int SEW_LG_MIN  = 3;   // 8-bit element
    localparam int SEW_LG_MAX  = 6;   // 64-bit element
    localparam int EMUL_LG_LIM = 3;   // grouping from 1/8 to 8
    localparam int CODE_W      = 2;   // width field bits
    localparam int TBL_W       = 2;   // relative table selector bits
    localparam int NUM_CODES   = 1 << CODE_W;

    typedef logic        [LG_W-1:0]    lg_t;
    typedef logic signed [LG_W-1:0]    slg_t;
    typedef logic signed [ARITH_W-1:0] sint_t;
    typedef logic        [CODE_W-1:0]  code_t;
    typedef logic        [TBL_W-1:0]   tbl_t;

    typedef struct packed {
        logic illegal;
        lg_t  d_eew;
        slg_t d_emul;
        lg_t  i_eew;
        slg_t i_emul;
    } eff_t;
endpackage

// File: rtl/vtype_state.sv
// Holds the vector type state: SEW, LMUL and the width-table mode.
// Assumes the writer supplies legal values; no check is made here.
module vtype_state
    import eew_pkg::*;
#(
    parameter int RESET_SEW_LG = SEW_LG_MIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  lg_t  sew_in,
    input  slg_t lmul_in,
    input  logic rel_in,
    input  tbl_t tbl_in,
    output lg_t  sew_q,
    output slg_t lmul_q,
    output logic rel_q,
    output tbl_t tbl_q
);
    // Capture a new type on a write; reset to SEW=8, LMUL=1, fixed table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sew_q  <= lg_t'(RESET_SEW_LG);
            lmul_q <= '0;
            rel_q  <= 1'b0;
            tbl_q  <= '0;
        end else if (we) begin
            sew_q  <= sew_in;
            lmul_q <= lmul_in;
            rel_q  <= rel_in;
            tbl_q  <= tbl_in;
        end
    end
endmodule

// File: rtl/width_select.sv
// Maps the instruction width field to an effective width (log2 bits).
// Indexed accesses always use the fixed index table {8,16,32,64};
// non-indexed use {8,16,32,SEW} or a relative table around SEW.
// Flags widths outside the supported element range.
module width_select
    import eew_pkg::*;
#(
    parameter int MIN_LG = SEW_LG_MIN,
    parameter int MAX_LG = SEW_LG_MAX
) (
    input  code_t code,
    input  logic  indexed,
    input  lg_t   sew,
    input  logic  rel,
    input  tbl_t  tbl,
    output sint_t eew,
    output logic  range_bad
);
    sint_t fixed_tbl [NUM_CODES];
    sint_t sew_s;
    sint_t rel_eew;

    // Fixed table entries: the minimum width scaled by the code.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_fixed
        assign fixed_tbl[g] = sint_t'(MIN_LG + g);
    end

    assign sew_s   = sint_t'({{(ARITH_W-LG_W){1'b0}}, sew});
    assign rel_eew = sew_s + sint_t'({{(ARITH_W-CODE_W){1'b0}}, code})
                   - sint_t'(NUM_CODES - 1)
                   + sint_t'({{(ARITH_W-TBL_W){1'b0}}, tbl});

    // Pick the width from the table that the access kind and mode select.
    always_comb begin
        if (indexed)
            eew = fixed_tbl[code];
        else if (rel)
            eew = rel_eew;
        else if (code == code_t'(NUM_CODES - 1))
            eew = sew_s;
        else
            eew = fixed_tbl[code];
    end

    assign range_bad = (eew < sint_t'(MIN_LG)) || (eew > sint_t'(MAX_LG));
endmodule

// File: rtl/group_calc.sv
// Computes the effective grouping log2 = LMUL + EEW - SEW so that the
// ratio of width to grouping is kept; flags results outside the range.
module group_calc
    import eew_pkg::*;
#(
    parameter int LIM = EMUL_LG_LIM
) (
    input  slg_t  lmul,
    input  sint_t eew,
    input  lg_t   sew,
    output sint_t emul,
    output logic  emul_bad
);
    sint_t lmul_s;
    sint_t sew_s;

    assign lmul_s = {{(ARITH_W-LG_W){lmul[LG_W-1]}}, lmul};
    assign sew_s  = sint_t'({{(ARITH_W-LG_W){1'b0}}, sew});

    // Grouping sum and its legality.
    always_comb begin
        emul     = lmul_s + eew - sew_s;
        emul_bad = (emul > sint_t'(LIM)) || (emul < -sint_t'(LIM));
    end
endmodule

// File: rtl/vls_eew_decode.sv
// Effective element width decoder for vector loads and stores.
// Holds the type state and, one cycle after an issue strobe, presents
// the effective data and index width/grouping or an illegal flag.
// Assumes configuration writes carry legal SEW and LMUL values.
module vls_eew_decode
    import eew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sew_lg,
    input  logic signed [2:0] cfg_lmul_lg,
    input  logic              cfg_rel_mode,
    input  logic [1:0]        cfg_rel_tbl,
    input  logic              iss_valid,
    input  logic              iss_indexed,
    input  logic [1:0]        iss_width,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [2:0]        out_data_eew_lg,
    output logic signed [2:0] out_data_emul_lg,
    output logic [2:0]        out_idx_eew_lg,
    output logic signed [2:0] out_idx_emul_lg
);
    lg_t   sew_q;
    slg_t  lmul_q;
    logic  rel_q;
    tbl_t  tbl_q;
    sint_t sel_eew;
    logic  rng_bad;
    sint_t sel_emul;
    logic  emul_bad;
    eff_t  eff_d;
    eff_t  eff_q;
    logic  valid_q;

    vtype_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sew_in  (cfg_sew_lg),
        .lmul_in (cfg_lmul_lg),
        .rel_in  (cfg_rel_mode),
        .tbl_in  (cfg_rel_tbl),
        .sew_q   (sew_q),
        .lmul_q  (lmul_q),
        .rel_q   (rel_q),
        .tbl_q   (tbl_q)
    );

    width_select u_width (
        .code      (iss_width),
        .indexed   (iss_indexed),
        .sew       (sew_q),
        .rel       (rel_q),
        .tbl       (tbl_q),
        .eew       (sel_eew),
        .range_bad (rng_bad)
    );

    group_calc u_group (
        .lmul     (lmul_q),
        .eew      (sel_eew),
        .sew      (sew_q),
        .emul     (sel_emul),
        .emul_bad (emul_bad)
    );

    // Route the selected width to the data or index side by access kind.
    always_comb begin
        eff_d = '0;
        if (rng_bad || emul_bad) begin
            eff_d.illegal = 1'b1;
        end else if (iss_indexed) begin
            eff_d.d_eew  = sew_q;
            eff_d.d_emul = lmul_q;
            eff_d.i_eew  = lg_t'(sel_eew);
            eff_d.i_emul = slg_t'(sel_emul);
        end else begin
            eff_d.d_eew  = lg_t'(sel_eew);
            eff_d.d_emul = slg_t'(sel_emul);
        end
    end

    // Register the result for one cycle per issue; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            eff_q   <= '0;
        end else begin
            valid_q <= iss_valid;
            eff_q   <= iss_valid ? eff_d : '0;
        end
    end

    assign out_valid        = valid_q;
    assign out_illegal      = eff_q.illegal;
    assign out_data_eew_lg  = eff_q.d_eew;
    assign out_data_emul_lg = eff_q.d_emul;
    assign out_idx_eew_lg   = eff_q.i_eew;
    assign out_idx_emul_lg  = eff_q.i_emul;
endmodule

// File: rtl/vls_eew_decode_chk.sv
// Property checker for vls_eew_decode, attached by bind below.
module vls_eew_decode_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              iss_valid,
    input logic              iss_indexed,
    input logic [2:0]        sew_q,
    input logic signed [2:0] lmul_q,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [2:0]        out_data_eew_lg,
    input logic signed [2:0] out_data_emul_lg,
    input logic [2:0]        out_idx_eew_lg,
    input logic signed [2:0] out_idx_emul_lg
);
    // R8: a result follows each issue by exactly one cycle.
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> !out_valid);

    // R8: idle cycles present an all-zero result.
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_illegal && out_data_eew_lg == 3'd0 &&
                        out_data_emul_lg == 3'sd0 && out_idx_eew_lg == 3'd0 &&
                        out_idx_emul_lg == 3'sd0));

    // R4: an illegal result carries no effective settings.
    p_illegal_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_data_eew_lg == 3'd0 &&
                         out_data_emul_lg == 3'sd0 && out_idx_eew_lg == 3'd0 &&
                         out_idx_emul_lg == 3'sd0));

    // R7: a legal result has a width between 8 and 64 bits.
    p_width_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal) |->
            (out_data_eew_lg >= 3'd3 && out_data_eew_lg <= 3'd6));

    // R5: for a legal indexed result, data and index keep the same ratio.
    p_index_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && $past(iss_indexed)) |->
            ($signed({1'b0, out_data_eew_lg}) - $signed({out_data_emul_lg[2], out_data_emul_lg}) ==
             $signed({1'b0, out_idx_eew_lg})  - $signed({out_idx_emul_lg[2], out_idx_emul_lg})));

    // R10: the stored type moves only on a configuration write.
    p_type_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(sew_q) && $stable(lmul_q)));
endmodule

bind vls_eew_decode vls_eew_decode_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .iss_valid        (iss_valid),
    .iss_indexed      (iss_indexed),
    .sew_q            (sew_q),
    .lmul_q           (lmul_q),
    .out_valid        (out_valid),
    .out_illegal      (out_illegal),
    .out_data_eew_lg  (out_data_eew_lg),
    .out_data_emul_lg (out_data_emul_lg),
    .out_idx_eew_lg   (out_idx_eew_lg),
    .out_idx_emul_lg  (out_idx_emul_lg)
);

// File: tb/vls_eew_decode_test.sv
// Self-checking bench: a vector table walked by one loop, then
// directed checks for reset, timing and type-state corner cases.
module vls_eew_decode_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_sew_lg = 3'd3;
    logic signed [2:0] cfg_lmul_lg = 3'sd0;
    logic              cfg_rel_mode = 1'b0;
    logic [1:0]        cfg_rel_tbl = 2'd0;
    logic              iss_valid = 1'b0;
    logic              iss_indexed = 1'b0;
    logic [1:0]        iss_width = 2'd0;
    logic              out_valid;
    logic              out_illegal;
    logic [2:0]        out_data_eew_lg;
    logic signed [2:0] out_data_emul_lg;
    logic [2:0]        out_idx_eew_lg;
    logic signed [2:0] out_idx_emul_lg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vls_eew_decode uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_we           (cfg_we),
        .cfg_sew_lg       (cfg_sew_lg),
        .cfg_lmul_lg      (cfg_lmul_lg),
        .cfg_rel_mode     (cfg_rel_mode),
        .cfg_rel_tbl      (cfg_rel_tbl),
        .iss_valid        (iss_valid),
        .iss_indexed      (iss_indexed),
        .iss_width        (iss_width),
        .out_valid        (out_valid),
        .out_illegal      (out_illegal),
        .out_data_eew_lg  (out_data_eew_lg),
        .out_data_emul_lg (out_data_emul_lg),
        .out_idx_eew_lg   (out_idx_eew_lg),
        .out_idx_emul_lg  (out_idx_emul_lg)
    );

    typedef struct packed {
        logic              rel;
        logic [1:0]        tbl;
        logic [2:0]        sew;
        logic signed [2:0] lmul;
        logic              idx;
        logic [1:0]        w;
        logic              ill;
        logic [2:0]        de;
        logic signed [2:0] dm;
        logic [2:0]        ie;
        logic signed [2:0] im;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 3'd4,  3'sd1, 1'b0, 2'd2, 1'b0, 3'd5, 3'sd2,  3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd4,  3'sd1, 1'b0, 2'd3, 1'b0, 3'd4, 3'sd1,  3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd3,  3'sd3, 1'b0, 2'd2, 1'b1, 3'd0, 3'sd0,  3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd6, -3'sd3, 1'b0, 2'd0, 1'b1, 3'd0, 3'sd0,  3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd6,  3'sd0, 1'b0, 2'd0, 1'b0, 3'd3, -3'sd3, 3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd5,  3'sd2, 1'b1, 2'd0, 1'b0, 3'd5, 3'sd2,  3'd3, 3'sd0},
        '{1'b0, 2'd0, 3'd3, -3'sd1, 1'b1, 2'd3, 1'b0, 3'd3, -3'sd1, 3'd6, 3'sd2},
        '{1'b0, 2'd0, 3'd3,  3'sd1, 1'b1, 2'd3, 1'b1, 3'd0, 3'sd0,  3'd0, 3'sd0},
        '{1'b1, 2'd0, 3'd4,  3'sd0, 1'b1, 2'd1, 1'b0, 3'd4, 3'sd0,  3'd4, 3'sd0},
        '{1'b1, 2'd0, 3'd4,  3'sd0, 1'b0, 2'd0, 1'b1, 3'd0, 3'sd0,  3'd0, 3'sd0},
        '{1'b1, 2'd0, 3'd6,  3'sd0, 1'b0, 2'd0, 1'b0, 3'd3, -3'sd3, 3'd0, 3'sd0},
        '{1'b1, 2'd3, 3'd5,  3'sd0, 1'b0, 2'd2, 1'b1, 3'd0, 3'sd0,  3'd0, 3'sd0},
        '{1'b1, 2'd1, 3'd4,  3'sd1, 1'b0, 2'd3, 1'b0, 3'd5, 3'sd2,  3'd0, 3'sd0},
        '{1'b1, 2'd2, 3'd3,  3'sd0, 1'b0, 2'd1, 1'b0, 3'd3, 3'sd0,  3'd0, 3'sd0},
        '{1'b0, 2'd0, 3'd5,  3'sd3, 1'b0, 2'd0, 1'b0, 3'd3, 3'sd1,  3'd0, 3'sd0}
    };

    // Compare the full output bundle and report one line on mismatch.
    task automatic check_out(input string tag, input logic valid_e, input logic ill_e,
                             input logic [2:0] de, input logic [2:0] dm,
                             input logic [2:0] ie, input logic [2:0] im);
        logic [12:0] act;
        logic [12:0] exp;
        act = {out_valid, out_illegal, out_data_eew_lg, out_data_emul_lg,
               out_idx_eew_lg, out_idx_emul_lg};
        exp = {valid_e, ill_e, de, dm, ie, im};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Write the type state for one cycle.
    task automatic write_cfg(input logic rel, input logic [1:0] tbl,
                             input logic [2:0] sew, input logic signed [2:0] lmul);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rel_mode = rel; cfg_rel_tbl = tbl;
        cfg_sew_lg = sew; cfg_lmul_lg = lmul;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue for one cycle; returns at the negedge where the result shows.
    task automatic issue(input logic idx, input logic [1:0] w);
        iss_valid = 1'b1; iss_indexed = idx; iss_width = w;
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    function automatic string vec_tag(input vec_t v);
        if (v.rel && v.ill) return "R7 relative range";
        if (v.ill)          return "R4 grouping range";
        if (v.idx)          return "R5 indexed";
        if (v.rel)          return "R6 relative table";
        return "R2 R3 fixed table";
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset leaves all outputs zero.
        check_out("R1 reset outputs", 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0);
        // R1: reset type is SEW=8, LMUL=1, fixed table.
        issue(1'b0, 2'd3);
        check_out("R1 reset type", 1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 3'd0);

        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i].rel, VEC[i].tbl, VEC[i].sew, VEC[i].lmul);
            issue(VEC[i].idx, VEC[i].w);
            check_out(vec_tag(VEC[i]), 1'b1, VEC[i].ill, VEC[i].de, VEC[i].dm,
                      VEC[i].ie, VEC[i].im);
        end

        // R8: the cycle after a result with no issue is all zero.
        @(negedge clk);
        check_out("R8 idle zero", 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0);

        // R9: write SEW=32 in the same cycle as an issue under SEW=16.
        write_cfg(1'b0, 2'd0, 3'd4, 3'sd0);
        cfg_we = 1'b1; cfg_sew_lg = 3'd5; cfg_lmul_lg = 3'sd0;
        iss_valid = 1'b1; iss_indexed = 1'b0; iss_width = 2'd3;
        @(negedge clk);
        cfg_we = 1'b0; iss_valid = 1'b0;
        check_out("R9 old type used", 1'b1, 1'b0, 3'd4, 3'd0, 3'd0, 3'd0);
        issue(1'b0, 2'd3);
        check_out("R9 new type next", 1'b1, 1'b0, 3'd5, 3'd0, 3'd0, 3'd0);

        // R10: an issue at a wider width leaves SEW=8 and LMUL=1 stored.
        write_cfg(1'b1, 2'd3, 3'd3, 3'sd0);
        issue(1'b0, 2'd1);
        check_out("R10 wide issue", 1'b1, 1'b0, 3'd4, 3'd1, 3'd0, 3'd0);
        issue(1'b0, 2'd0);
        check_out("R10 type unchanged", 1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 3'd0);

        // R5: index width code 3 is 64 bits in relative mode too.
        issue(1'b1, 2'd3);
        check_out("R5 index 64 in relative mode", 1'b1, 1'b0, 3'd3, 3'd0, 3'd6, 3'd3);

        // R8: back-to-back issues each give a result.
        write_cfg(1'b0, 2'd0, 3'd4, 3'sd0);
        iss_valid = 1'b1; iss_indexed = 1'b0; iss_width = 2'd0;
        @(negedge clk);
        check_out("R8 back-to-back first", 1'b1, 1'b0, 3'd3, 3'b111, 3'd0, 3'd0);
        iss_width = 2'd2;
        @(negedge clk);
        iss_valid = 1'b0;
        check_out("R8 back-to-back second", 1'b1, 1'b0, 3'd5, 3'd1, 3'd0, 3'd0);

        // R1: reset in the middle clears the stored type.
        write_cfg(1'b1, 2'd2, 3'd6, 3'sd2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(1'b0, 2'd3);
        check_out("R1 reset clears type", 1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 3'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule